// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, from the destination address at the head of each frame, whether the frame should be kept. The six address bytes arrive one per clock when `byte_valid_i` is high. The first byte of a frame is marked by `sof_i`. While the bytes stream past, the block keeps a running byte-wise CRC for the hash lookup and a set of running comparison flags. One clock after the sixth byte it presents a registered verdict.

There are five mode inputs. Perfect matching on a single programmed unicast address can be inverted. Group-addressed frames go through a 64-bin hash table, or are all admitted in pass-all-multicast mode. The all-ones broadcast address can be refused. Promiscuous mode admits everything. Pass-all mode also admits everything, but still reports through `filt_fail_o` whether the normal filter would have refused the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: `valid_o` rises one clock after the sixth address byte of a frame is taken. It holds its value, together with `accept_o` and `filt_fail_o`, until a new frame starts. A byte taken with `sof_i` clears `valid_o` on the next clock. The first byte of a frame is the byte presented with `sof_i` high.
- R2: Address byte k (k = 0 for the first byte) is compared with `perf_addr_i[8k+7:8k]`. A frame whose group bit (bit 0 of byte 0) is 0 is accepted when all six bytes are equal to the programmed address, and rejected otherwise.
- R3: A non-broadcast frame with the group bit set is accepted when `hash_tbl_i[idx]` is 1.
  - `idx` is bits 31:26 of a 32-bit CRC register after the six bytes have been shifted in.
  - The register starts at all ones. Each byte is shifted in LSB first: on each bit, if register bit 0 XOR the data bit is 1, the register becomes (register >> 1) XOR 32'hEDB88320; otherwise it becomes register >> 1.
  - No final complement is applied.
  - Because of this layout, idx bit 5 selects the upper word [63:32] of `hash_tbl_i`.
- R4: With `mcast_all_i` set, every non-broadcast frame with the group bit set is accepted, whatever the hash table holds.
- R5: The all-ones address is accepted unless `bcast_rej_i` is set. Broadcast refusal takes precedence over `mcast_all_i`.
- R6: With `inverse_i` set, a frame with the group bit clear is accepted only if it differs from the programmed address.
- R7: `promisc_i` accepts every frame and overrides every other mode. `filt_fail_o` still reports the result of the normal filter.
- R8: With `pass_all_i` set, every frame is accepted. `filt_fail_o` is 1 exactly when the filter, without promiscuous or pass-all mode, would reject the frame. In all modes, `filt_fail_o` is the inverse of the filter result.
- R9: Bytes that arrive without `sof_i` before any frame has started, or after the sixth byte, are ignored. A byte with `sof_i` in the middle of an address restarts the frame.
- R10: After reset, `valid_o`, `accept_o` and `filt_fail_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A destination address byte is present |
| sof_i | input | 1 | Marks the first address byte of a frame |
| byte_i | input | 8 | Address byte |
| perf_addr_i | input | 48 | Perfect-match address, byte k at bits 8k+7:8k |
| hash_tbl_i | input | 64 | Multicast hash bins |
| promisc_i | input | 1 | Accept all frames |
| pass_all_i | input | 1 | Accept all frames, report filter result |
| mcast_all_i | input | 1 | Accept all group-addressed frames |
| inverse_i | input | 1 | Invert the perfect unicast match |
| bcast_rej_i | input | 1 | Refuse broadcast frames |
| valid_o | output | 1 | Verdict is valid |
| accept_o | output | 1 | Frame is accepted |
| filt_fail_o | output | 1 | Frame failed the address filter |

## Verification
The assertions assume that the mode inputs, the programmed address and the hash table stay constant from the first byte of a frame until the verdict has been read. They also assume that `sof_i` is only high together with `byte_valid_i`. The stimulus changes the configuration only between frames and always drives `sof_i` together with a valid byte. Random idle gaps are inserted between bytes so that the verdict timing is exercised with both back-to-back and gapped arrivals.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef struct packed {
    logic promisc;
    logic pass_all;
    logic mcast_all;
    logic inverse;
    logic bcast_rej;
  } filt_mode_t;

  // one byte into the reflected CRC register, LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_filt_crc.sv
module rx_filt_crc
  import rx_filt_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [7:0]        byte_i,
  output logic [HASH_W-1:0] idx_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_step(first_i ? CRC_INIT : crc_q, byte_i);
    idx_o = crc_d[31 -: HASH_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (take_i) crc_q <= crc_d;
endmodule

// File: rtl/rx_filt_match.sv
module rx_filt_match #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    first_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] perf_addr_i,
  output logic                    eq_o,
  output logic                    ones_o,
  output logic                    group_o
);
  logic       eq_q, ones_q, group_q;
  logic [7:0] ref_byte;

  always_comb begin
    ref_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_i == IDX_W'(k)) ref_byte = perf_addr_i[8*k +: 8];
  end

  // flags include the current byte
  assign eq_o    = (first_i | eq_q) & (byte_i == ref_byte);
  assign ones_o  = (first_i | ones_q) & (&byte_i);
  assign group_o = first_i ? byte_i[0] : group_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      eq_q    <= 1'b0;
      ones_q  <= 1'b0;
      group_q <= 1'b0;
    end else if (take_i) begin
      eq_q    <= eq_o;
      ones_q  <= ones_o;
      group_q <= group_o;
    end
endmodule

// File: rtl/rx_filt_decide.sv
module rx_filt_decide
  import rx_filt_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic                 eq_i,
  input  logic                 ones_i,
  input  logic                 group_i,
  input  logic [HASH_W-1:0]    hash_idx_i,
  input  logic [2**HASH_W-1:0] hash_tbl_i,
  input  filt_mode_t           mode_i,
  output logic                 pass_o,
  output logic                 accept_o
);
  always_comb begin
    if (ones_i)       pass_o = ~mode_i.bcast_rej;
    else if (group_i) pass_o = mode_i.mcast_all | hash_tbl_i[hash_idx_i];
    else              pass_o = mode_i.inverse ^ eq_i;
    accept_o = mode_i.promisc | mode_i.pass_all | pass_o;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_valid_i,
  input  logic                    sof_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] perf_addr_i,
  input  logic [2**HASH_W-1:0]    hash_tbl_i,
  input  logic                    promisc_i,
  input  logic                    pass_all_i,
  input  logic                    mcast_all_i,
  input  logic                    inverse_i,
  input  logic                    bcast_rej_i,
  output logic                    valid_o,
  output logic                    accept_o,
  output logic                    filt_fail_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q, idx;
  logic              take, first, last;
  logic [HASH_W-1:0] hash_idx;
  logic              eq, ones, group, pass, acc;
  filt_mode_t        mode;

  assign mode  = '{promisc: promisc_i, pass_all: pass_all_i, mcast_all: mcast_all_i,
                   inverse: inverse_i, bcast_rej: bcast_rej_i};
  assign first = sof_i;
  assign idx   = sof_i ? '0 : cnt_q;
  assign take  = byte_valid_i & (sof_i | (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
  assign last  = take & (idx == CNT_W'(ADDR_BYTES - 1));

  rx_filt_crc #(.HASH_W(HASH_W)) u_crc (
    .clk_i, .rst_ni, .take_i(take), .first_i(first), .byte_i, .idx_o(hash_idx)
  );

  rx_filt_match #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(CNT_W)) u_match (
    .clk_i, .rst_ni, .take_i(take), .first_i(first), .idx_i(idx), .byte_i,
    .perf_addr_i, .eq_o(eq), .ones_o(ones), .group_o(group)
  );

  rx_filt_decide #(.HASH_W(HASH_W)) u_decide (
    .eq_i(eq), .ones_i(ones), .group_i(group), .hash_idx_i(hash_idx),
    .hash_tbl_i, .mode_i(mode), .pass_o(pass), .accept_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else if (take) cnt_q <= idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      accept_o    <= 1'b0;
      filt_fail_o <= 1'b0;
    end else if (last) begin
      valid_o     <= 1'b1;
      accept_o    <= acc;
      filt_fail_o <= ~pass;
    end else if (take && first) begin
      valid_o <= 1'b0;
    end

  assert_valid_after_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> valid_o);
  assert_sof_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && sof_i && ADDR_BYTES > 1) |=> !valid_o);
  assert_hold_verdict_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !(byte_valid_i && sof_i)) |=>
      (valid_o && $stable(accept_o) && $stable(filt_fail_o)));
  assert_promisc_accepts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && promisc_i) |=> accept_o);
  assert_pass_all_accepts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && pass_all_i) |=> accept_o);
  assert_reject_implies_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept_o) |-> filt_fail_o);
  assert_stray_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !sof_i && cnt_q == '0) |=> $stable(cnt_q) && $stable(valid_o));
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0, sof = 1'b0;
  logic [7:0]  din = '0;
  logic [47:0] perf = '0;
  logic [63:0] tbl = '0;
  logic        promisc = 0, pass_all = 0, mcast_all = 0, inverse = 0, bcast_rej = 0;
  logic        valid, accept, fail;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .sof_i(sof), .byte_i(din),
    .perf_addr_i(perf), .hash_tbl_i(tbl), .promisc_i(promisc), .pass_all_i(pass_all),
    .mcast_all_i(mcast_all), .inverse_i(inverse), .bcast_rej_i(bcast_rej),
    .valid_o(valid), .accept_o(accept), .filt_fail_o(fail)
  );

  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb = c[0] ^ a[n];
      c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c[31:26];
  endfunction

  // {accept, fail}
  function automatic logic [1:0] ref_dec(logic [47:0] a);
    logic ok;
    if (a == '1)   ok = !bcast_rej;
    else if (a[0]) ok = mcast_all || tbl[ref_idx(a)];
    else           ok = inverse ? (a != perf) : (a == perf);
    return {promisc | pass_all | ok, !ok};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic send(logic [47:0] a, int n, bit with_sof, bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bv = 1'b1; sof = with_sof && (k == 0); din = a[8*k +: 8];
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); bv = 1'b0; sof = 1'b0;
      end
    end
    @(negedge clk);
    bv = 1'b0; sof = 1'b0;
  endtask

  task automatic frame(string tag, logic [47:0] a, bit gaps);
    logic [1:0] e;
    e = ref_dec(a);
    send(a, 6, 1'b1, gaps);
    check({tag, " valid"}, 32'(valid), 32'd1);
    check({tag, " accept"}, 32'(accept), 32'(e[1]));
    check({tag, " fail"}, 32'(fail), 32'(e[0]));
  endtask

  task automatic set_mode(bit p, bit pa, bit ma, bit inv, bit br);
    promisc = p; pass_all = pa; mcast_all = ma; inverse = inv; bcast_rej = br;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] mc, a;
    logic [1:0]  e;
    string       tag;
    void'($urandom(32'd2718));
    perf = 48'hA1B2_C3D4_E5F6;   // byte0 = F6, group bit 0
    repeat (3) @(negedge clk);
    check("R10 valid", 32'(valid), 0);
    check("R10 accept", 32'(accept), 0);
    check("R10 fail", 32'(fail), 0);
    rst_n = 1'b1;

    // R9: bytes with no frame started
    send(perf, 3, 1'b0, 1'b0);
    check("R9 stray before sof", 32'(valid), 0);

    set_mode(0, 0, 0, 0, 0);
    frame("R2 perfect hit", perf, 1'b0);
    frame("R2 perfect miss byte5", perf ^ 48'h0100_0000_0000, 1'b0);

    // R9: extra bytes after the sixth leave verdict unchanged
    send(48'h0, 2, 1'b0, 1'b0);
    check("R9 extra bytes valid", 32'(valid), 1);
    check("R9 extra bytes accept", 32'(accept), 0);
    check("R9 extra bytes fail", 32'(fail), 1);

    // R1 restart clears valid; R9 restart mid-address
    send(48'hFFFF_FF00_0000, 3, 1'b1, 1'b0);
    check("R1 sof clears valid", 32'(valid), 0);
    frame("R9 restart", perf, 1'b0);

    mc = 48'h0000_5E00_0001;
    tbl = 64'h0;
    tbl[ref_idx(mc)] = 1'b1;
    frame("R3 hash hit", mc, 1'b0);
    tbl = ~tbl;
    frame("R3 hash miss", mc, 1'b0);
    set_mode(0, 0, 1, 0, 0);
    frame("R4 mcast all", mc, 1'b0);
    set_mode(0, 0, 0, 0, 0);
    frame("R5 bcast accept", '1, 1'b0);
    set_mode(0, 0, 1, 0, 1);
    frame("R5 bcast reject over mcast all", '1, 1'b0);
    set_mode(0, 0, 0, 1, 0);
    frame("R6 inverse perfect", perf, 1'b0);
    frame("R6 inverse other", 48'h0000_0000_1234, 1'b0);
    set_mode(1, 0, 0, 0, 1);
    frame("R7 promisc bcast", '1, 1'b0);
    set_mode(0, 1, 0, 0, 0);
    frame("R8 pass all miss", 48'h1111_2222_3332, 1'b0);
    frame("R8 pass all hit", perf, 1'b0);

    for (int i = 0; i < 400; i++) begin
      tbl = {$urandom, $urandom};
      set_mode($urandom % 4 == 0, $urandom % 4 == 0, $urandom % 2 == 0,
               $urandom % 2 == 0, $urandom % 2 == 0);
      case ($urandom % 5)
        0: a = perf;
        1: a = perf ^ (48'h1 << ($urandom % 48));
        2: a = '1;
        3: a = {$urandom, $urandom} | 48'h1;
        default: a = {$urandom, $urandom} & ~48'h1;
      endcase
      e = ref_dec(a);
      if (promisc) tag = "R7 random";
      else if (pass_all) tag = "R8 random";
      else if (a == '1) tag = "R5 random";
      else if (a[0]) tag = mcast_all ? "R4 random" : "R3 random";
      else tag = inverse ? "R6 random" : "R2 random";
      if (e[1] === 1'bx) tag = {tag, " x"};
      frame(tag, a, 1'b1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule